// File: doc/BRIEF.md
# Clock Divider Update Sequencer

This block rewrites six clock-divider control words to the settings of one of four performance levels. A single strobe with a 2-bit level starts a pass. The words are updated one at a time and always in the same order. Each update is a read-modify-write: the divider fields of the word are cleared and loaded with the level's values, and every other bit keeps its value.

After each write the block watches that group's status input. It moves on only when the status bits named in the group's busy mask have all cleared. A one-cycle done pulse ends a full pass. If a group stays busy longer than a configurable number of cycles, the pass is abandoned and an error flag is raised.

The divider words are held in flops inside the block and driven out on dedicated ports. The status words come from the divider hardware that the block controls.

Top module: `clkdiv_update_seq`

## Requirements
- R1: A pass writes the groups in this order: cpu0, cpu1, mem, top, lbus, rbus. Each group is written once, and at most one group word changes in any cycle.
- R2: Divider field i of a group is 3 bits wide at bits 4i+2..4i. The cpu1 group is the exception: its first field sits at bits 6..4 and its second at bits 2..0. The field counts are cpu0 7, cpu1 2, mem 8, top 5, lbus 2, rbus 2.
- R3: A write changes only the divider field bits. All other bits of the word keep their previous value, which after reset is the group's reset parameter.
- R4: The field values are listed in field order for levels 0/1, level 2 and level 3. Levels 0 and 1 are identical.
  - cpu0: {0,3,7,3,3,0,1}, {0,1,3,1,3,0,1}, {0,0,1,0,3,1,1}
  - cpu1: {3,0} at every level
  - mem: {3,1,1,1,1,1,3,1}, {7,1,1,2,1,1,3,1}, {7,1,1,3,1,1,3,1}
  - top: {3,7,4,5,1}, {4,7,5,7,1}, {5,7,7,7,1}
  - lbus and rbus share the values {3,1}, {4,1}, {5,1}.
- R5: After a group is written, the block waits until that group's status ANDed with its busy mask is zero. The masks are cpu0 0x1111111, cpu1 0x11, mem 0x11111111, top 0x11111, lbus 0x11 and rbus 0x11. Status bits outside the mask have no effect. With no busy bits set, a pass takes 13 clock edges from the edge that accepts the start to done.
- R6: A start strobe that arrives while a pass is in progress is ignored. The pass continues with the level it was started with.
- R7: done_o is high for exactly one cycle, on the cycle after the rbus status is seen clear.
- R8: If a group's masked status is seen busy on TIMEOUT consecutive wait cycles, the pass stops. err_o is set, groups after that one stay unchanged and no done is given. err_o holds until the next accepted start clears it.
- R9: After reset, every group word equals its reset parameter, and done_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a pass (accepted only when idle) |
| level_i | input | 2 | Performance level for the pass |
| cpu0_stat_i | input | 32 | cpu0 divider status |
| cpu1_stat_i | input | 32 | cpu1 divider status |
| mem_stat_i | input | 32 | Memory-controller divider status |
| top_stat_i | input | 32 | Top bus divider status |
| lbus_stat_i | input | 32 | Left bus divider status |
| rbus_stat_i | input | 32 | Right bus divider status |
| cpu0_div_o | output | 32 | cpu0 divider word |
| cpu1_div_o | output | 32 | cpu1 divider word |
| mem_div_o | output | 32 | Memory-controller divider word |
| top_div_o | output | 32 | Top bus divider word |
| lbus_div_o | output | 32 | Left bus divider word |
| rbus_div_o | output | 32 | Right bus divider word |
| done_o | output | 1 | One-cycle pass-complete pulse |
| err_o | output | 1 | Busy timeout abort flag |

## Verification
The bench builds the block with TIMEOUT = 12. This keeps the abort path within a few cycles, so busy stalls of exactly 11 cycles (must pass) and a group stuck busy forever (must abort) can both be exercised in the same run. The reset parameters have every non-divider bit set, or a mixed pattern, so any read-modify-write that disturbs a bit outside the fields shows up in the output words. Every write then also changes the word, which lets the bench see the write order.

// File: rtl/clkdiv_seq_pkg.sv
package clkdiv_seq_pkg;
  localparam int NGRP = 6;
  localparam int DW   = 32;
  localparam int GW   = $clog2(NGRP);

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_WAIT} seq_st_t;

  // bits owned by the divider fields of each group
  function automatic logic [DW-1:0] field_clear(input logic [GW-1:0] g);
    case (g)
      3'd0:    return 32'h0777_7777;
      3'd1:    return 32'h0000_0077;
      3'd2:    return 32'h7777_7777;
      3'd3:    return 32'h0007_7777;
      default: return 32'h0000_0077;
    endcase
  endfunction

  function automatic logic [DW-1:0] busy_mask(input logic [GW-1:0] g);
    case (g)
      3'd0:    return 32'h0111_1111;
      3'd1:    return 32'h0000_0011;
      3'd2:    return 32'h1111_1111;
      3'd3:    return 32'h0001_1111;
      default: return 32'h0000_0011;
    endcase
  endfunction

  // packed field values; levels 0 and 1 coincide
  function automatic logic [DW-1:0] level_word(input logic [GW-1:0] g, input logic [1:0] lvl);
    logic [1:0] row;
    row = (lvl == 2'd0) ? 2'd1 : lvl;
    case (g)
      3'd0: case (row)
              2'd2:    return 32'h0103_1310;
              2'd3:    return 32'h0113_0100;
              default: return 32'h0103_3730;
            endcase
      3'd1: return 32'h0000_0030;
      3'd2: case (row)
              2'd2:    return 32'h1311_2117;
              2'd3:    return 32'h1311_3117;
              default: return 32'h1311_1113;
            endcase
      3'd3: case (row)
              2'd2:    return 32'h0001_7574;
              2'd3:    return 32'h0001_7775;
              default: return 32'h0001_5473;
            endcase
      default: case (row)
              2'd2:    return 32'h0000_0014;
              2'd3:    return 32'h0000_0015;
              default: return 32'h0000_0013;
            endcase
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_seq_ctrl.sv
module clkdiv_seq_ctrl
  import clkdiv_seq_pkg::*;
#(
  parameter int TIMEOUT = 1024,
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [1:0]               level_i,
  input  logic [NGRP-1:0][DW-1:0] status_i,
  output logic                     wr_en_o,
  output logic [GW-1:0]            wr_grp_o,
  output logic [1:0]               wr_lvl_o,
  output logic                     active_o,
  output logic                     done_o,
  output logic                     err_o
);
  seq_st_t        st;
  logic [GW-1:0]  grp;
  logic [1:0]     lvl;
  logic [TW-1:0]  tmr;
  logic           grp_clear;

  assign grp_clear = (status_i[grp] & busy_mask(grp)) == '0;
  assign wr_en_o   = (st == ST_WRITE);
  assign wr_grp_o  = grp;
  assign wr_lvl_o  = lvl;
  assign active_o  = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      grp    <= '0;
      lvl    <= '0;
      tmr    <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          lvl   <= level_i;
          grp   <= '0;
          err_o <= 1'b0;
          st    <= ST_WRITE;
        end
        ST_WRITE: begin
          tmr <= '0;
          st  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (grp_clear) begin
            if (grp == GW'(NGRP - 1)) begin
              done_o <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              grp <= grp + 1'b1;
              st  <= ST_WRITE;
            end
          end else if (tmr == TW'(TIMEOUT - 1)) begin
            err_o <= 1'b1;
            st    <= ST_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkdiv_seq_regbank.sv
module clkdiv_seq_regbank
  import clkdiv_seq_pkg::*;
#(
  parameter logic [NGRP*DW-1:0] RST_VEC = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [GW-1:0]            wr_grp_i,
  input  logic [1:0]               wr_lvl_i,
  output logic [NGRP-1:0][DW-1:0] div_o
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [GW-1:0] GI = GW'(g);
    always_ff @(posedge clk) begin
      if (!rst_n)
        div_o[g] <= RST_VEC[g*DW +: DW];
      else if (wr_en_i && wr_grp_i == GI)
        div_o[g] <= (div_o[g] & ~field_clear(GI)) | level_word(GI, wr_lvl_i);
    end
  end
endmodule

// File: rtl/clkdiv_update_seq.sv
module clkdiv_update_seq
  import clkdiv_seq_pkg::*;
#(
  parameter int          TIMEOUT  = 1024,
  parameter logic [31:0] RST_CPU0 = 32'h0,
  parameter logic [31:0] RST_CPU1 = 32'h0,
  parameter logic [31:0] RST_MEM  = 32'h0,
  parameter logic [31:0] RST_TOP  = 32'h0,
  parameter logic [31:0] RST_LBUS = 32'h0,
  parameter logic [31:0] RST_RBUS = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [1:0]  level_i,
  input  logic [31:0] cpu0_stat_i,
  input  logic [31:0] cpu1_stat_i,
  input  logic [31:0] mem_stat_i,
  input  logic [31:0] top_stat_i,
  input  logic [31:0] lbus_stat_i,
  input  logic [31:0] rbus_stat_i,
  output logic [31:0] cpu0_div_o,
  output logic [31:0] cpu1_div_o,
  output logic [31:0] mem_div_o,
  output logic [31:0] top_div_o,
  output logic [31:0] lbus_div_o,
  output logic [31:0] rbus_div_o,
  output logic        done_o,
  output logic        err_o
);
  localparam logic [NGRP*DW-1:0] RST_VEC =
    {RST_RBUS, RST_LBUS, RST_TOP, RST_MEM, RST_CPU1, RST_CPU0};

  logic [NGRP-1:0][DW-1:0] stat_q;
  logic [NGRP-1:0][DW-1:0] div_q;
  logic                    wr_en;
  logic [GW-1:0]           wr_grp;
  logic [1:0]              wr_lvl;
  logic                    seq_active;

  assign stat_q = {rbus_stat_i, lbus_stat_i, top_stat_i, mem_stat_i, cpu1_stat_i, cpu0_stat_i};

  clkdiv_seq_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_i(level_i),
    .status_i(stat_q), .wr_en_o(wr_en), .wr_grp_o(wr_grp), .wr_lvl_o(wr_lvl),
    .active_o(seq_active), .done_o(done_o), .err_o(err_o)
  );

  clkdiv_seq_regbank #(.RST_VEC(RST_VEC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_grp_i(wr_grp),
    .wr_lvl_i(wr_lvl), .div_o(div_q)
  );

  assign cpu0_div_o = div_q[0];
  assign cpu1_div_o = div_q[1];
  assign mem_div_o  = div_q[2];
  assign top_div_o  = div_q[3];
  assign lbus_div_o = div_q[4];
  assign rbus_div_o = div_q[5];
endmodule

// File: rtl/clkdiv_update_seq_chk.sv
module clkdiv_update_seq_chk
  import clkdiv_seq_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic [NGRP-1:0][DW-1:0] div_q,
  input logic                     seq_active,
  input logic                     done_o,
  input logic                     err_o
);
  logic [NGRP-1:0][DW-1:0] prev_div;
  logic                    prev_act;
  logic [NGRP-1:0]         chg;

  always_ff @(posedge clk) begin
    prev_div <= div_q;
    prev_act <= seq_active;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_chg
    localparam logic [GW-1:0] GI = GW'(g);
    assign chg[g] = div_q[g] != prev_div[g];
    assert_keep_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q[g] & ~field_clear(GI)) == (prev_div[g] & ~field_clear(GI)));
  end

  assert_one_group_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chg) <= 1);
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |-> prev_act);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !err_o);
endmodule

bind clkdiv_update_seq clkdiv_update_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .div_q(div_q), .seq_active(seq_active),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/clkdiv_update_seq_bench.sv
module clkdiv_update_seq_bench;
  localparam int TMO = 12;
  localparam logic [31:0] R0 = 32'hFFFF_FFFF, R1V = 32'hA5A5_A5A5, R2V = 32'h8888_8888,
                          R3V = 32'hFFFF_FFFF, R4V = 32'hCAFE_F00D, R5V = 32'h0000_0088;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] level = 0;
  logic [31:0] stat [6];
  logic [31:0] dv [6];
  logic done, err;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  clkdiv_update_seq #(.TIMEOUT(TMO), .RST_CPU0(R0), .RST_CPU1(R1V), .RST_MEM(R2V),
    .RST_TOP(R3V), .RST_LBUS(R4V), .RST_RBUS(R5V)) u_clkdiv_update_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .level_i(level),
    .cpu0_stat_i(stat[0]), .cpu1_stat_i(stat[1]), .mem_stat_i(stat[2]),
    .top_stat_i(stat[3]), .lbus_stat_i(stat[4]), .rbus_stat_i(stat[5]),
    .cpu0_div_o(dv[0]), .cpu1_div_o(dv[1]), .mem_div_o(dv[2]),
    .top_div_o(dv[3]), .lbus_div_o(dv[4]), .rbus_div_o(dv[5]),
    .done_o(done), .err_o(err));

  // ---------------- reference tables ----------------
  function automatic int nfld(int g);
    case (g) 0: return 7; 1: return 2; 2: return 8; 3: return 5; default: return 2; endcase
  endfunction
  function automatic int fpos(int g, int i);
    if (g == 1) return (i == 0) ? 4 : 0;
    return 4 * i;
  endfunction
  function automatic int fval(int g, int lvl, int i);
    int r;
    int c0 [3][7] = '{'{0,3,7,3,3,0,1}, '{0,1,3,1,3,0,1}, '{0,0,1,0,3,1,1}};
    int mm [3][8] = '{'{3,1,1,1,1,1,3,1}, '{7,1,1,2,1,1,3,1}, '{7,1,1,3,1,1,3,1}};
    int tp [3][5] = '{'{3,7,4,5,1}, '{4,7,5,7,1}, '{5,7,7,7,1}};
    int bs [3][2] = '{'{3,1}, '{4,1}, '{5,1}};
    r = (lvl <= 1) ? 0 : lvl - 1;
    case (g)
      0: return c0[r][i];
      1: return (i == 0) ? 3 : 0;
      2: return mm[r][i];
      3: return tp[r][i];
      default: return bs[r][i];
    endcase
  endfunction
  function automatic logic [31:0] bmask(int g);
    logic [31:0] m = 0;
    for (int i = 0; i < 8; i++) if (i < nfld(g) || (g == 0 && i < 7)) m[4*i] = 1'b1;
    if (g == 1 || g >= 4) m = 32'h11;
    return m;
  endfunction
  function automatic logic [31:0] apply(int g, int lvl, logic [31:0] base);
    logic [31:0] w = base;
    for (int i = 0; i < nfld(g); i++) begin
      w = w & ~(32'h7 << fpos(g, i));
      w = w | (32'(fval(g, lvl, i)) << fpos(g, i));
    end
    return w;
  endfunction

  // ---------------- busy model ----------------
  logic [31:0] prev_dv [6];
  int cnt [6];
  bit stuck [6];
  int maxd = 0;
  bit fixd = 0;
  int last_g = -1;
  bit order_bad = 0;

  initial for (int g = 0; g < 6; g++) begin stat[g] = 0; cnt[g] = 0; stuck[g] = 0; end

  always @(negedge clk) begin
    for (int g = 0; g < 6; g++) begin
      logic [31:0] junk;
      junk = $urandom & ~bmask(g);
      if (rst_n && dv[g] !== prev_dv[g]) begin
        if (g < last_g) order_bad = 1;
        last_g = g;
        cnt[g] = fixd ? maxd : ((maxd == 0) ? 0 : int'($urandom_range(maxd, 0)));
      end else if (cnt[g] > 0) cnt[g]--;
      stat[g] = (cnt[g] > 0 || stuck[g]) ? (junk | bmask(g)) : junk;
      prev_dv[g] = dv[g];
    end
  end

  // ---------------- helpers ----------------
  logic [31:0] expq [6];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(string req);
    for (int g = 0; g < 6; g++) chk(dv[g] === expq[g], req, $sformatf("group %0d word", g), dv[g], expq[g]);
  endtask

  // run a pass; returns edges to done (or 0 if none), done width, err
  task automatic run(int lvl, int mid_lvl, output int edges, output int dw, output bit e);
    int c = 0;
    edges = 0; dw = 0; e = 0;
    last_g = -1; order_bad = 0;
    @(negedge clk); start = 1; level = 2'(lvl);
    @(negedge clk); start = 0; c = 1;
    while (c < 400) begin
      if (done) begin dw++; if (edges == 0) edges = c; end
      else if (edges != 0) break;
      if (err) begin e = 1; break; end
      if (c == 3 && mid_lvl >= 0) begin start = 1; level = 2'(mid_lvl); end
      else start = 0;
      @(negedge clk); c++;
    end
    start = 0;
  endtask

  task automatic full_pass(int lvl, int mid, string req);
    int edges, dw; bit e;
    run(lvl, mid, edges, dw, e);
    for (int g = 0; g < 6; g++) expq[g] = apply(g, lvl, expq[g]);
    chk(edges != 0 && !e, "R7", "done reached", 32'(edges), 32'd1);
    chk(dw == 1, "R7", "done width", 32'(dw), 32'd1);
    chk(!order_bad, "R1", "write order", 32'(order_bad), 32'd0);
    check_regs(req);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int edges, dw; bit e;
    void'($urandom(32'h5EED));
    expq[0] = R0; expq[1] = R1V; expq[2] = R2V; expq[3] = R3V; expq[4] = R4V; expq[5] = R5V;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check_regs("R9");
    chk(!done && !err, "R9", "done/err after reset", {30'd0, done, err}, 32'd0);

    // R5 R7 timing with no busy: 13 edges, junk status bits ignored
    maxd = 0; fixd = 0;
    run(3, -1, edges, dw, e);
    for (int g = 0; g < 6; g++) expq[g] = apply(g, 3, expq[g]);
    chk(edges == 13, "R5", "edges to done, idle status", 32'(edges), 32'd13);
    chk(dw == 1, "R7", "done width", 32'(dw), 32'd1);
    chk(!order_bad, "R1", "write order", 32'(order_bad), 32'd0);
    check_regs("R2");

    // directed levels R4
    full_pass(0, -1, "R4");
    full_pass(2, -1, "R4");
    full_pass(1, -1, "R4");

    // R5 boundary: every group busy exactly TMO-1 cycles must pass
    maxd = TMO - 1; fixd = 1;
    full_pass(3, -1, "R5");
    fixd = 0;

    // R6 start during pass ignored
    maxd = 3;
    full_pass(0, 2, "R6");

    // random passes R3 R4 R5
    for (int k = 0; k < 20; k++) begin
      maxd = int'($urandom_range(TMO - 1, 0));
      full_pass(int'($urandom_range(3, 0)), -1, "R3");
    end

    // R8 timeout abort on mem group
    maxd = 2; fixd = 0; stuck[2] = 1;
    run(2, -1, edges, dw, e);
    for (int g = 0; g < 3; g++) expq[g] = apply(g, 2, expq[g]);
    chk(e == 1, "R8", "err raised", 32'(e), 32'd1);
    chk(edges == 0, "R8", "no done on abort", 32'(edges), 32'd0);
    repeat (5) @(negedge clk);
    chk(err === 1'b1, "R8", "err holds", 32'(err), 32'd1);
    check_regs("R8");
    stuck[2] = 0;
    repeat (3) @(negedge clk);
    full_pass(3, -1, "R8");
    chk(err === 1'b0, "R8", "err cleared by new start", 32'(err), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule